// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits in front of a memory and peripheral bus and judges every access against a small table of protection regions. Each access carries an address, a kind (data read, data write or instruction fetch) and a privilege flag. The block answers with a grant or a deny in the same cycle. A deny also leaves a registered fault record behind, so a fault handler can find out what went wrong.

Privileged code loads the region table through a single-beat register-write port. This is the reload an operating system performs when it switches tasks. Each region is a power-of-two block whose base is aligned to its own size, and it carries separate read, write and execute-never permissions. A region that allows reads but not writes can be laid over the bottom of a task stack, so that a write into it shows up as a stack overflow. A global enable bit turns checking on. A privileged-default bit lets privileged accesses that hit no region go through.

Top module: `prot_region_checker`

## Requirements
- R1: After reset the global enable is off, every region is disabled, `fault_valid` and `fault_pulse` are low, and every access is granted.
- R2: While the global enable (control bit 0) is off, every valid access is granted, whatever its address, kind or privilege.
- R3: A region matches an address when the two agree above bit `s`. Here `s` is the size field (attribute bits 5:1), raised to 5 when it is smaller, so the smallest region is 32 bytes. Base bits below `s` are ignored. A region matches only while its enable bit (attribute bit 0) is set.
- R4: A matching region grants a read only when read-allowed (attribute bit 6) is set, and a write only when write-allowed (attribute bit 7) is set. A read-only region therefore works as a stack guard that denies writes and grants reads.
- R5: A matching region grants an instruction fetch (`acc_kind` 2) only when read-allowed is set and execute-never (attribute bit 8) is clear.
- R6: When several enabled regions match, the highest-numbered one alone decides.
- R7: With checking on, an access that matches no region is denied, with one exception: a privileged access is granted when the privileged-default bit (control bit 1) is set.
- R8: Configuration writes (`cfg_kind` 0 = region base, 1 = region attributes, 2 = control, 3 = clear fault) take effect only when `cfg_priv` is high. An unprivileged one changes nothing and raises a fault with kind 3, address 0 and privilege 0.
- R9: A denied access produces `fault_pulse` for exactly the next cycle. If the record was empty, the same edge captures the access address, its kind (0 read, 1 write, 2 fetch) and its privilege flag, and sets `fault_valid`.
- R10: The fault record keeps its first fault. Later faults do not overwrite it. It stays until a privileged clear write empties it.
- R11: `acc_grant` and `acc_deny` are combinational, valid in the cycle the access is presented, and low when `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_grant | output | 1 | Access may proceed |
| acc_deny | output | 1 | Access is blocked |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Configuration writer is privileged |
| cfg_kind | input | 2 | 0 base, 1 attributes, 2 control, 3 clear fault |
| cfg_idx | input | IDX_W | Region index for base and attribute writes |
| cfg_wdata | input | ADDR_W | Write data |
| fault_pulse | output | 1 | One-cycle pulse after any fault |
| fault_valid | output | 1 | Fault record holds a fault |
| fault_addr | output | ADDR_W | Recorded faulting address |
| fault_kind | output | 2 | Recorded kind, 3 for a configuration violation |
| fault_priv | output | 1 | Recorded privilege flag |

## Verification
Assertions check on every cycle that a disabled checker grants, that an unprivileged miss is denied, that an unprivileged configuration write leaves the control bits alone, that a deny is followed by a fault pulse with a valid record, and that a held record stays unchanged until it is cleared. Some behaviour only the bench scenarios can show. These are the address arithmetic of region matching (alignment masking, the 32-byte floor), the winner among overlapping regions, the execute-never and stack-guard permissions, the privileged-default fallback, and the exact contents of the fault record.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_CFG   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_ATTR  = 2'd1,
    CFG_CTRL  = 2'd2,
    CFG_CLEAR = 2'd3
  } cfg_kind_e;

  // bit0 enable, bits5:1 size log2, bit6 read, bit7 write, bit8 execute-never
  typedef struct packed {
    logic       xn;
    logic       wr_ok;
    logic       rd_ok;
    logic [4:0] size_log2;
    logic       en;
  } region_attr_t;

  localparam int ATTR_W = $bits(region_attr_t);

endpackage

// File: rtl/prc_region_table.sv
module prc_region_table
  import prc_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_priv,
  input  logic [1:0]           cfg_kind,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  output logic [ADDR_W-1:0]    region_base [NUM_REGIONS],
  output region_attr_t         region_attr [NUM_REGIONS],
  output logic                 glb_en,
  output logic                 pdef_en,
  output logic                 clear_req,
  output logic                 cfg_viol
);

  logic      wr_ok;
  cfg_kind_e kind;
  logic      ctrl_load;
  logic      glb_en_d, pdef_en_d;

  always_comb begin
    kind      = cfg_kind_e'(cfg_kind);
    wr_ok     = cfg_we && cfg_priv;
    cfg_viol  = cfg_we && !cfg_priv;
    clear_req = wr_ok && (kind == CFG_CLEAR);
    ctrl_load = wr_ok && (kind == CFG_CTRL);
    glb_en_d  = cfg_wdata[0];
    pdef_en_d = cfg_wdata[1];
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_entry
    logic base_load, attr_load;

    always_comb begin
      base_load = wr_ok && (kind == CFG_BASE) && (cfg_idx == IDX_W'(i));
      attr_load = wr_ok && (kind == CFG_ATTR) && (cfg_idx == IDX_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        region_base[i] <= '0;
        region_attr[i] <= '0;
      end else begin
        if (base_load) region_base[i] <= cfg_wdata;
        if (attr_load) region_attr[i] <= region_attr_t'(cfg_wdata[ATTR_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      pdef_en <= 1'b0;
    end else if (ctrl_load) begin
      glb_en  <= glb_en_d;
      pdef_en <= pdef_en_d;
    end
  end

  AST_UNPRIV_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_priv |=> $stable(glb_en) && $stable(pdef_en)); // R8

endmodule

// File: rtl/prc_match.sv
module prc_match
  import prc_pkg::*;
#(
  parameter int NUM_REGIONS   = 8,
  parameter int ADDR_W        = 32,
  parameter int MIN_SIZE_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [1:0]           acc_kind,
  input  logic                 acc_priv,
  input  logic [ADDR_W-1:0]    region_base [NUM_REGIONS],
  input  region_attr_t         region_attr [NUM_REGIONS],
  input  logic                 glb_en,
  input  logic                 pdef_en,
  output logic                 allow
);

  logic [NUM_REGIONS-1:0] hit;
  logic [NUM_REGIONS-1:0] permit;
  logic                   any_hit;
  logic                   win_permit;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
    logic [4:0]        eff_sz;
    logic [ADDR_W-1:0] mask;

    always_comb begin
      eff_sz = region_attr[i].size_log2;
      if (int'(eff_sz) < MIN_SIZE_LOG2) eff_sz = 5'(MIN_SIZE_LOG2);
      if (int'(eff_sz) >= ADDR_W) mask = '0;
      else                        mask = {ADDR_W{1'b1}} << eff_sz;
      hit[i] = region_attr[i].en &&
               ((acc_addr & mask) == (region_base[i] & mask));
      unique case (acc_kind_e'(acc_kind))
        ACC_READ:  permit[i] = region_attr[i].rd_ok;
        ACC_WRITE: permit[i] = region_attr[i].wr_ok;
        default:   permit[i] = region_attr[i].rd_ok && !region_attr[i].xn;
      endcase
    end
  end

  // ascending scan: the last (highest-numbered) hit overrides earlier ones
  always_comb begin
    any_hit    = 1'b0;
    win_permit = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit[i]) begin
        any_hit    = 1'b1;
        win_permit = permit[i];
      end
    end
    if (!glb_en)      allow = 1'b1;
    else if (any_hit) allow = win_permit;
    else              allow = acc_priv && pdef_en;
  end

  AST_UNPRIV_MISS_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    glb_en && !acc_priv && (hit == '0) |-> !allow); // R7

endmodule

// File: rtl/prc_fault_rec.sv
module prc_fault_rec
  import prc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_deny,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  input  logic              cfg_viol,
  input  logic              clear_req,
  output logic              fault_pulse,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [1:0]        fault_kind,
  output logic              fault_priv
);

  logic              evt, capture;
  logic              valid_d;
  logic [ADDR_W-1:0] addr_d;
  logic [1:0]        kind_d;
  logic              priv_d;

  always_comb begin
    evt     = acc_deny || cfg_viol;
    capture = evt && (!fault_valid || clear_req);
    if (acc_deny) begin
      addr_d = acc_addr;
      kind_d = acc_kind;
      priv_d = acc_priv;
    end else begin
      addr_d = '0;
      kind_d = ACC_CFG;
      priv_d = 1'b0;
    end
    if (capture)        valid_d = 1'b1;
    else if (clear_req) valid_d = 1'b0;
    else                valid_d = fault_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_pulse <= 1'b0;
      fault_valid <= 1'b0;
    end else begin
      fault_pulse <= evt;
      fault_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr <= '0;
      fault_kind <= '0;
      fault_priv <= 1'b0;
    end else if (capture) begin
      fault_addr <= addr_d;
      fault_kind <= kind_d;
      fault_priv <= priv_d;
    end
  end

  AST_DENY_RAISES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_deny |=> fault_pulse && fault_valid); // R9
  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !clear_req |=> fault_valid && $stable(fault_addr) && $stable(fault_kind)); // R10

endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker
  import prc_pkg::*;
#(
  parameter int NUM_REGIONS   = 8,   // 8 or 16
  parameter int ADDR_W        = 32,
  parameter int MIN_SIZE_LOG2 = 5,
  localparam int IDX_W        = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  output logic              acc_grant,
  output logic              acc_deny,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic [1:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              fault_pulse,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [1:0]        fault_kind,
  output logic              fault_priv
);

  logic [ADDR_W-1:0] region_base [NUM_REGIONS];
  region_attr_t      region_attr [NUM_REGIONS];
  logic              glb_en, pdef_en, clear_req, cfg_viol, allow;

  prc_region_table #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .region_base(region_base), .region_attr(region_attr),
    .glb_en(glb_en), .pdef_en(pdef_en),
    .clear_req(clear_req), .cfg_viol(cfg_viol)
  );

  prc_match #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .MIN_SIZE_LOG2(MIN_SIZE_LOG2)
  ) u_match (
    .clk(clk), .rst_n(rst_n),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
    .region_base(region_base), .region_attr(region_attr),
    .glb_en(glb_en), .pdef_en(pdef_en), .allow(allow)
  );

  always_comb begin
    acc_grant = acc_valid && allow;
    acc_deny  = acc_valid && !allow;
  end

  prc_fault_rec #(.ADDR_W(ADDR_W)) u_fault (
    .clk(clk), .rst_n(rst_n),
    .acc_deny(acc_deny), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_priv(acc_priv), .cfg_viol(cfg_viol), .clear_req(clear_req),
    .fault_pulse(fault_pulse), .fault_valid(fault_valid),
    .fault_addr(fault_addr), .fault_kind(fault_kind), .fault_priv(fault_priv)
  );

  AST_OFF_GRANTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !glb_en |-> acc_grant && !acc_deny); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_grant && !acc_deny); // R11

endmodule

// File: tb/prot_region_checker_test.sv
`timescale 1ns/1ps
module prot_region_checker_test;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_kind = '0;
  logic          acc_priv = 1'b0;
  logic          acc_grant, acc_deny;
  logic          cfg_we = 1'b0;
  logic          cfg_priv = 1'b0;
  logic [1:0]    cfg_kind = '0;
  logic [2:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          fault_pulse, fault_valid, fault_priv;
  logic [AW-1:0] fault_addr;
  logic [1:0]    fault_kind;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  prot_region_checker uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_priv(acc_priv), .acc_grant(acc_grant), .acc_deny(acc_deny),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .fault_pulse(fault_pulse), .fault_valid(fault_valid),
    .fault_addr(fault_addr), .fault_kind(fault_kind), .fault_priv(fault_priv)
  );

  function automatic logic [AW-1:0] mk_attr(int sz, bit rd, bit wr, bit xn);
    return AW'(1) | (AW'(sz) << 1) | (AW'(rd) << 6) | (AW'(wr) << 7) | (AW'(xn) << 8);
  endfunction

  task automatic check(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access per cycle, expectation pushed to the scoreboard
  task automatic access(logic [AW-1:0] a, logic [1:0] k, bit p, bit exp, string tag);
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic cfg(logic [1:0] k, int idx, logic [AW-1:0] d, bit p);
    @(negedge clk);
    acc_valid = 1'b0; cfg_we = 1'b1; cfg_kind = k; cfg_idx = 3'(idx);
    cfg_wdata = d; cfg_priv = p;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic chk_fault(bit pulse, bit valid, logic [AW-1:0] a, logic [1:0] k, bit p, string tag);
    idle();
    #1;
    check(fault_pulse == pulse, {tag, " pulse"}, AW'(fault_pulse), AW'(pulse));
    check(fault_valid == valid, {tag, " valid"}, AW'(fault_valid), AW'(valid));
    if (valid) begin
      check(fault_addr == a, {tag, " addr"}, fault_addr, a);
      check(fault_kind == k, {tag, " kind"}, AW'(fault_kind), AW'(k));
      check(fault_priv == p, {tag, " priv"}, AW'(fault_priv), AW'(p));
    end
  endtask

  // monitor: compares the same-cycle decision against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(acc_grant == e && acc_deny == !e, t, AW'({acc_grant, acc_deny}), AW'({e, !e}));
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(fault_valid == 0 && fault_pulse == 0, "R1 reset record", AW'({fault_valid, fault_pulse}), 0);
    access(32'h9000_0000, 2'd1, 1'b0, 1'b1, "R1 access granted after reset");
    // R2: checking off, regions loaded but global enable clear
    cfg(2'd1, 0, mk_attr(12, 1, 0, 0), 1'b1);
    access(32'h0000_0000, 2'd1, 1'b0, 1'b1, "R2 write granted while off");
    access(32'h7000_0000, 2'd2, 1'b0, 1'b1, "R2 fetch granted while off");

    // region table
    cfg(2'd0, 0, 32'h2000_0000, 1'b1);
    cfg(2'd1, 0, mk_attr(12, 1, 1, 1), 1'b1);   // 4 KB data, no execute
    cfg(2'd0, 1, 32'h2000_0000, 1'b1);
    cfg(2'd1, 1, mk_attr(5, 1, 0, 1), 1'b1);    // 32 B stack guard
    cfg(2'd0, 2, 32'h0000_0000, 1'b1);
    cfg(2'd1, 2, mk_attr(16, 1, 0, 0), 1'b1);   // 64 KB code
    cfg(2'd0, 3, 32'h4000_0000, 1'b1);
    cfg(2'd1, 3, mk_attr(3, 1, 1, 1), 1'b1);    // size 3 raised to 32 B
    cfg(2'd0, 4, 32'h3000_0010, 1'b1);          // unaligned base
    cfg(2'd1, 4, mk_attr(8, 1, 0, 1), 1'b1);
    cfg(2'd0, 5, 32'h6000_0000, 1'b1);
    cfg(2'd1, 5, mk_attr(12, 1, 1, 0) & ~32'h1, 1'b1); // disabled entry
    cfg(2'd2, 0, 32'h1, 1'b1);                  // enable, no default map

    access(32'h2000_0FFC, 2'd0, 1'b0, 1'b1, "R3 read at region top");
    access(32'h2000_1000, 2'd0, 1'b0, 1'b0, "R3 read just past region");
    access(32'h3000_0004, 2'd0, 1'b0, 1'b1, "R3 base low bits ignored");
    access(32'h4000_001C, 2'd0, 1'b0, 1'b1, "R3 32-byte floor inside");
    access(32'h4000_0020, 2'd0, 1'b0, 1'b0, "R3 32-byte floor outside");
    access(32'h6000_0000, 2'd0, 1'b0, 1'b0, "R3 disabled region ignored");
    access(32'h2000_0100, 2'd1, 1'b0, 1'b1, "R4 write to data region");
    access(32'h2000_0010, 2'd0, 1'b0, 1'b1, "R4 read in stack guard");
    access(32'h3000_0008, 2'd1, 1'b1, 1'b0, "R4 write to read-only region");
    access(32'h2000_0100, 2'd2, 1'b0, 1'b0, "R5 fetch from execute-never");
    access(32'h0000_1000, 2'd2, 1'b0, 1'b1, "R5 fetch from code region");
    access(32'h2000_001F, 2'd1, 1'b0, 1'b0, "R6 overlap higher region denies write");
    access(32'h2000_0020, 2'd1, 1'b0, 1'b1, "R6 just above guard granted");
    access(32'h5000_0000, 2'd0, 1'b1, 1'b0, "R7 privileged miss denied without default");
    cfg(2'd3, 0, 32'h0, 1'b1);
    idle();
    #1;
    check(fault_valid == 0, "R10 privileged clear empties record", AW'(fault_valid), 0);

    // R9 record capture
    access(32'h2000_0008, 2'd1, 1'b1, 1'b0, "R11 stack overflow write denied same cycle");
    chk_fault(1, 1, 32'h2000_0008, 2'd1, 1'b1, "R9 record of guard write");
    access(32'h5555_0000, 2'd2, 1'b0, 1'b0, "R7 unprivileged miss denied");
    chk_fault(1, 1, 32'h2000_0008, 2'd1, 1'b1, "R10 first fault kept");
    chk_fault(0, 1, 32'h2000_0008, 2'd1, 1'b1, "R9 pulse lasts one cycle");
    cfg(2'd3, 0, 32'h0, 1'b0);                  // unprivileged clear
    chk_fault(1, 1, 32'h2000_0008, 2'd1, 1'b1, "R10 unprivileged clear ignored");
    cfg(2'd3, 0, 32'h0, 1'b1);
    chk_fault(0, 0, 0, 0, 0, "R10 cleared");

    // R8 unprivileged configuration
    cfg(2'd2, 0, 32'h0, 1'b0);                  // try to disable checking
    chk_fault(1, 1, 32'h0, 2'd3, 1'b0, "R8 config violation record");
    access(32'h5000_0000, 2'd0, 1'b0, 1'b0, "R8 control unchanged");
    cfg(2'd1, 1, mk_attr(5, 1, 1, 0), 1'b0);    // try to open stack guard
    access(32'h2000_0010, 2'd1, 1'b0, 1'b0, "R8 region attributes unchanged");

    // R7 privileged default map
    cfg(2'd2, 0, 32'h3, 1'b1);
    access(32'h5000_0000, 2'd1, 1'b1, 1'b1, "R7 privileged miss uses default map");
    access(32'h5000_0000, 2'd1, 1'b0, 1'b0, "R7 unprivileged miss still denied");
    access(32'h2000_0010, 2'd1, 1'b1, 1'b0, "R7 matched region overrides default map");
    cfg(2'd2, 0, 32'h0, 1'b1);
    access(32'h2000_0010, 2'd1, 1'b0, 1'b1, "R2 disabled again grants");
    idle();
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule